// File: doc/BRIEF.md
# Gated Per-Second Rate Meter

This block measures how often each of a group of trigger lines fires. Every line is brought into the sampling clock domain, and each rising edge adds one to a live counter for that line. A free-running timebase marks off fixed gate intervals, one second at the default 80 MHz sampling clock. At the end of each interval, the block copies every live count into a holding register. One cycle later it zeroes the live counters, so the next interval starts clean.

The holding registers always show the result of the last finished interval. A host reads one line at a time by giving its index on the read port. The held value appears one clock later, with the count in the low bits and an overflow flag above them. A live counter that would pass its maximum stays at all-ones and raises the flag until the next clear. Reading never affects counting.

Top module: `rate_meter_bank`

## Requirements
- R1: A trigger line is passed through a two-stage synchroniser. A line that goes high and stays high adds exactly one count, however long it stays high.
- R2: For each line, the captured count of an interval equals the number of rising edges counted in that interval.
- R3: When a live counter is at all-ones and another edge arrives, the count stays at all-ones. The overflow flag is then set and stays set until the next clear. It is read back as bit CNT_W of `rd_data`.
- R4: The capture happens on the GATE_CYCLES-th clock edge after reset is released, and then once every GATE_CYCLES edges.
- R5: The live counters are cleared on the edge right after a capture, and the overflow flag is cleared with them. An edge counted on that clearing edge belongs to the new interval, so the new interval starts at 1.
- R6: An edge counted on the capture edge itself is included in the captured value.
- R7: A holding register does not change between two capture edges.
- R8: `rd_data` shows, one edge after `rd_idx` is applied, the holding register of that line. Bits [CNT_W-1:0] hold the count and bit CNT_W holds the overflow flag.
- R9: While reset is held low, the read output, the live counters and the holding registers are all zero.
- R10: The lines are independent. Activity on one line never changes the count of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_in | input | NUM_CH | Trigger lines, asynchronous to clk |
| rd_idx | input | $clog2(NUM_CH) | Index of the line to read |
| rd_data | output | CNT_W+1 | Held result: overflow flag in the top bit, count below it |

## Verification
Edge counting can coincide with the capture edge, and again with the clear edge that follows it. Both collisions are provoked on purpose by timing one trigger pulse so that its synchronised edge lands exactly on the capture edge, and another so that it lands on the clear edge. The first must appear in the result being captured. The second must appear as a count of one in the next interval's result, and neither may be lost or counted twice. A behavioural reference model follows the pipeline latency and the gate position and is compared with the read port on every clock. Directed checks also compare each line against a count worked out from the pulses driven.

// File: rtl/rm_pkg.sv
`timescale 1ns/1ps
// Shared constants for the rate meter bank.
// Assumes nothing; only provides defaults used by the top and its submodules.
package rm_pkg;
    localparam int RM_DEF_CHANNELS = 16;
    localparam int RM_DEF_CNT_W    = 24;
    localparam int RM_DEF_GATE     = 80_000_000;
endpackage

// File: rtl/rm_edge_sync.sv
`timescale 1ns/1ps
// Brings asynchronous trigger lines into the clk domain and flags rising edges.
// Assumes each high or low phase of a trigger lasts at least one clock period.
// A rising edge is reported for exactly one cycle, two edges after the line is first sampled high.
module rm_edge_sync #(
    parameter int NUM_CH = rm_pkg::RM_DEF_CHANNELS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] trig_i,
    output logic [NUM_CH-1:0] rise_o
);
    logic [NUM_CH-1:0] meta_q;
    logic [NUM_CH-1:0] sync_q;
    logic [NUM_CH-1:0] prev_q;

    // Two-flop synchroniser followed by one history flop per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= trig_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // A line is newly high when its synchronised level is 1 and its history is 0.
    assign rise_o = sync_q & ~prev_q;

    // R1: no line reports a rising edge in two consecutive cycles.
    assert_single_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/rm_gate_timer.sv
`timescale 1ns/1ps
// Timebase that defines the measurement gate.
// latch_o is high for one cycle every GATE_CYCLES cycles.
// clear_o is high in the cycle right after latch_o.
// Assumes GATE_CYCLES >= 2, so that the two pulses never overlap.
module rm_gate_timer #(
    parameter int GATE_CYCLES = rm_pkg::RM_DEF_GATE
) (
    input  logic clk,
    input  logic rst_n,
    output logic latch_o,
    output logic clear_o
);
    localparam int GATE_W = (GATE_CYCLES > 1) ? $clog2(GATE_CYCLES) : 1;
    localparam logic [GATE_W-1:0] LAST_TICK = GATE_W'(GATE_CYCLES - 1);

    logic [GATE_W-1:0] tick_q;
    logic              at_end;
    logic              clear_q;

    assign at_end = (tick_q == LAST_TICK);

    // Free-running tick counter that wraps at the end of each gate.
    always_ff @(posedge clk) begin
        if (!rst_n)      tick_q <= '0;
        else if (at_end) tick_q <= '0;
        else             tick_q <= tick_q + 1'b1;
    end

    // Delay the capture strobe by one cycle to make the clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) clear_q <= 1'b0;
        else        clear_q <= at_end;
    end

    assign latch_o = at_end;
    assign clear_o = clear_q;

    // R4: a capture is always followed by a clear, never by a second capture.
    assert_latch_then_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        latch_o |=> (clear_o && !latch_o));
    // R5: capture and clear never fall in the same cycle.
    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(latch_o && clear_o));
endmodule

// File: rtl/rm_rate_channel.sv
`timescale 1ns/1ps
// One line of the rate meter: a live saturating counter with a sticky overflow flag,
// and a holding register that keeps the last finished interval.
// Assumes that latch_i and clear_i are one-cycle strobes in different cycles,
// with clear_i coming right after latch_i.
module rm_rate_channel #(
    parameter int CNT_W = rm_pkg::RM_DEF_CNT_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rise_i,
    input  logic           latch_i,
    input  logic           clear_i,
    output logic [CNT_W:0] hold_o
);
    logic [CNT_W-1:0] live_q;
    logic             ovf_q;
    logic [CNT_W-1:0] nxt_cnt;
    logic             nxt_ovf;
    logic [CNT_W:0]   hold_q;

    // Next live value: add one, or stay at all-ones and raise the flag.
    always_comb begin
        nxt_cnt = live_q;
        nxt_ovf = ovf_q;
        if (rise_i) begin
            if (&live_q) nxt_ovf = 1'b1;
            else         nxt_cnt = live_q + 1'b1;
        end
    end

    // Live counter: restart on clear, keeping an edge that arrives in that same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
            ovf_q  <= 1'b0;
        end else if (clear_i) begin
            live_q <= {{(CNT_W-1){1'b0}}, rise_i};
            ovf_q  <= 1'b0;
        end else begin
            live_q <= nxt_cnt;
            ovf_q  <= nxt_ovf;
        end
    end

    // Holding register: capture the value including any edge counted on the capture edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       hold_q <= '0;
        else if (latch_i) hold_q <= {nxt_ovf, nxt_cnt};
    end

    assign hold_o = hold_q;

    // R3: once set, the overflow flag holds until a clear.
    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clear_i) |=> ovf_q);
    // R3: an overflowed count sits at all-ones.
    assert_ovf_saturated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> (&live_q));
    // R5: after a clear the live count is 0 or 1 and the flag is low.
    assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> ((live_q <= CNT_W'(1)) && !ovf_q));
    // R7: the holding register changes only on a capture edge.
    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_i |=> $stable(hold_q));
endmodule

// File: rtl/rate_meter_bank.sv
`timescale 1ns/1ps
// Bank of gated rate meters with a registered, indexed read port.
// Assumes that NUM_CH >= 2, CNT_W >= 2 and GATE_CYCLES >= 2.
// rd_idx is sampled on every edge and the selected held value appears on the next edge.
module rate_meter_bank #(
    parameter int NUM_CH      = rm_pkg::RM_DEF_CHANNELS,
    parameter int CNT_W       = rm_pkg::RM_DEF_CNT_W,
    parameter int GATE_CYCLES = rm_pkg::RM_DEF_GATE
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH-1:0]         trig_in,
    input  logic [$clog2(NUM_CH)-1:0] rd_idx,
    output logic [CNT_W:0]            rd_data
);
    localparam int IDX_W   = $clog2(NUM_CH);
    localparam int TAB_LEN = 2 ** IDX_W;

    logic [NUM_CH-1:0] rise_w;
    logic              latch_w;
    logic              clear_w;
    logic [CNT_W:0]    hold_w  [NUM_CH];
    logic [CNT_W:0]    sel_tab [TAB_LEN];
    logic [CNT_W:0]    rd_q;

    rm_edge_sync #(.NUM_CH(NUM_CH)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (trig_in),
        .rise_o (rise_w)
    );

    rm_gate_timer #(.GATE_CYCLES(GATE_CYCLES)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .latch_o (latch_w),
        .clear_o (clear_w)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        rm_rate_channel #(.CNT_W(CNT_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .rise_i  (rise_w[ch]),
            .latch_i (latch_w),
            .clear_i (clear_w),
            .hold_o  (hold_w[ch])
        );
    end

    // Pad the held values up to a power-of-two table so every index is defined.
    for (genvar ix = 0; ix < TAB_LEN; ix++) begin : g_tab
        if (ix < NUM_CH) begin : g_real
            assign sel_tab[ix] = hold_w[ix];
        end else begin : g_pad
            assign sel_tab[ix] = '0;
        end
    end

    // Registered read mux: one cycle from index to data.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= sel_tab[rd_idx];
    end

    assign rd_data = rd_q;

    // R8, R3: a flagged readout always carries a saturated count.
    assert_read_saturated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[CNT_W] |-> (&rd_data[CNT_W-1:0]));
    // R9: the read output is zero right after a reset cycle.
    assert_reset_zero_R9: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0));
endmodule

// File: tb/rate_meter_bank_bench.sv
`timescale 1ns/1ps
// Self-checking bench for rate_meter_bank, with a short gate and a narrow counter.
module rate_meter_bank_bench;
    localparam int NCH  = 16;
    localparam int CW   = 6;
    localparam int GATE = 200;
    localparam int MAXV = (1 << CW) - 1;
    localparam int LAST_N = 850;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NCH-1:0]  trig;
    logic [3:0]      rd_idx;
    logic [CW:0]     rd_data;

    int n;          // edges counted since reset release
    int errs = 0;
    int checks = 0;
    bit done = 0;

    // Reference model state.
    bit [NCH-1:0] h1, h2, h3;
    int m_live [NCH];
    bit m_ovf  [NCH];
    int m_hold [NCH];
    bit m_hovf [NCH];
    bit m_clr;
    int m_g;
    int m_rd;

    always #10 clk = ~clk;

    rate_meter_bank #(.NUM_CH(NCH), .CNT_W(CW), .GATE_CYCLES(GATE)) u_rate_meter_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_in (trig),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s n=%0d actual=%0h expected=%0h", tag, n, act, exp);
        end
    endtask

    // Trigger level for line c, driven just after edge number k.
    function automatic bit stim(input int k, input int c);
        if (c == 5) return k >= 10;
        if (k >= 10 && k < 200 && ((k - 10) % 4) < 2 && ((k - 10) / 4) < c + 1) return 1'b1;
        if (c == 0) return (k >= 205 && k <= 345 && (k % 2) == 1);
        if (c == 1) return (k == 420 || k == 421 || k == 424 || k == 425 || k == 597 || k == 598);
        if (c == 2) return (k == 430 || k == 431 || k == 598 || k == 599);
        return 1'b0;
    endfunction

    // Expected held result for interval m on line c, worked out from the pulses driven.
    function automatic int expect_of(input int m, input int c);
        case (m)
            1: return (c == 5) ? 1 : c + 1;
            2: return (c == 0) ? ((1 << CW) | MAXV) : 0;
            3: return (c == 1) ? 3 : ((c == 2) ? 1 : 0);
            default: return (c == 2) ? 1 : 0;
        endcase
    endfunction

    function automatic string tag_of(input int m, input int c);
        if (m == 1) return (c == 5) ? "R1" : "R2";
        if (m == 2) return (c == 0) ? "R3" : "R10";
        if (m == 3) return (c == 1) ? "R6" : ((c <= 2) ? "R5" : "R10");
        return (c == 2) ? "R5" : ((c == 1) ? "R6" : "R10");
    endfunction

    // Behavioural reference: sample history, gate position, live/held values and read latency.
    always @(posedge clk) begin
        if (!rst_n) begin
            n = 0; h1 = '0; h2 = '0; h3 = '0; m_clr = 0; m_g = 0; m_rd = 0;
            for (int c = 0; c < NCH; c++) begin
                m_live[c] = 0; m_ovf[c] = 0; m_hold[c] = 0; m_hovf[c] = 0;
            end
        end else begin
            bit latch;
            n++;
            m_rd = (int'(m_hovf[rd_idx]) << CW) | m_hold[rd_idx];
            latch = (m_g == GATE - 1);
            for (int c = 0; c < NCH; c++) begin
                bit r;
                int nl;
                bit no;
                r = h2[c] & ~h3[c];
                nl = m_live[c]; no = m_ovf[c];
                if (r) begin
                    if (nl == MAXV) no = 1; else nl = nl + 1;
                end
                if (latch) begin m_hold[c] = nl; m_hovf[c] = no; end
                if (m_clr) begin m_live[c] = r ? 1 : 0; m_ovf[c] = 0; end
                else       begin m_live[c] = nl; m_ovf[c] = no; end
            end
            h3 = h2; h2 = h1; h1 = trig;
            m_clr = latch;
            m_g = latch ? 0 : m_g + 1;
        end
    end

    // Stimulus and checks, all at the falling edge.
    initial begin
        rst_n = 1'b0; trig = '0; rd_idx = '0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(rd_data == '0, "R9", int'(rd_data), 0);
            rd_idx = 4'(i);
        end
        rst_n = 1'b1;
        while (n < LAST_N) begin
            @(negedge clk);
            // R8: the read port matches the model on every clock.
            chk(int'(rd_data) == m_rd, "R8", int'(rd_data), m_rd);
            if (n == 200) chk(rd_data == '0, "R4", int'(rd_data), 0);
            if (n == 201) chk(int'(rd_data) == expect_of(1, 8), "R4", int'(rd_data), expect_of(1, 8));
            if (n >= 380 && n <= 395)
                chk(int'(rd_data) == expect_of(1, (n - 1) % 16), "R7", int'(rd_data), expect_of(1, (n - 1) % 16));
            for (int m = 1; m <= 4; m++) begin
                if (n >= m * GATE + 10 && n <= m * GATE + 41)
                    chk(int'(rd_data) == expect_of(m, (n - 1) % 16), tag_of(m, (n - 1) % 16),
                        int'(rd_data), expect_of(m, (n - 1) % 16));
            end
            for (int c = 0; c < NCH; c++) trig[c] = stim(n, c);
            rd_idx = 4'(n % 16);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(20 * 5000);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog n=%0d actual=running expected=finished", n);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule